// File: doc/BRIEF.md
# Byte Register Bus Slave

This block is a slave on a Wishbone classic bus that holds a bank of 8-bit registers behind a 32-bit data path. Each 32-bit word carries four registers, one per byte lane. The register at the lowest byte offset of a word sits in the most significant lane. The address lines carry only the word number. The byte within the word comes from a one-hot byte select, and the block rebuilds the full register index from the two.

A write takes its byte from the lane that the select names and ignores the other three lanes. A master writing one byte may place the same byte on all lanes. A read returns the addressed byte on that same lane, and the other lanes read as zero. Every request is completed with a one-cycle acknowledge. A request that names no register is acknowledged and has no effect. The full register contents are also driven out in parallel for the logic they control.

Top module: `wbb_byte_regs`

## Requirements
- R1: A request (cyc_i and stb_i both high) seen at a rising edge while ack_o is low gives ack_o high in the next cycle. When the master drops the request at the edge where it sees ack_o, ack_o is low in the following cycle, so each request gets exactly one ack cycle.
- R2: ack_o is never high while cyc_i or stb_i is low, and a strobe without cyc_i causes no ack and no write.
- R3: The register index is adr_i[7:2]*4 plus the byte offset. The offset comes from sel_i: 1000 gives 0, 0100 gives 1, 0010 gives 2 and 0001 gives 3. A write (we_i high) stores dat_i lane bits [31-8*off : 24-8*off] into that register.
- R4: On a write, the three lanes not named by sel_i have no effect on any register.
- R5: A read (we_i low) returns the addressed register on lane [31-8*off : 24-8*off] of dat_o during the ack cycle, with the other three lanes zero.
- R6: A sel_i value that is not one-hot (including 0000) is acknowledged. It writes nothing and reads as all zeros.
- R7: While rst_ni is low (asynchronous, active low), all registers are zero and ack_o is low.
- R8: dat_o is all zeros whenever ack_o is low.
- R9: regs_o bits [8*k+7 : 8*k] always show register k.
- R10: A request whose index is NUM_REGS or more is acknowledged, writes nothing and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | High for a write |
| adr_i | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| sel_i | input | 4 | One-hot byte select, MSB is offset 0 |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack |
| ack_o | output | 1 | Transfer acknowledge |
| regs_o | output | 8*NUM_REGS | Parallel view of all registers |

## Verification
Assertions check the following on every cycle: ack stays within the request and lasts one cycle, a pending request is answered, at most one lane of read data is non-zero, a register changes only on a write to its own index, and a request that misses reads back zero. Only the bench scenarios can show the mapping from select and address to the right register and lane. The same holds for ignoring off-lane write data, rejecting bad selects and out-of-range indices, and the reset contents, because each of these needs a reference model of the register values.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned BUS_W  = LANES * LANE_W;

  // big-endian lanes: offset 0 sits in the top lane
  function automatic logic [1:0] sel_to_off(input logic [LANES-1:0] sel);
    case (sel)
      4'b1000: return 2'd0;
      4'b0100: return 2'd1;
      4'b0010: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] lane_get(input logic [BUS_W-1:0] bus, input logic [1:0] off);
    return bus[BUS_W-1-LANE_W*off -: LANE_W];
  endfunction

  function automatic logic [BUS_W-1:0] lane_put(input logic [LANE_W-1:0] b, input logic [1:0] off);
    return {b, {(BUS_W-LANE_W){1'b0}}} >> (LANE_W * off);
  endfunction
endpackage

// File: rtl/wbb_lane_decode.sv
module wbb_lane_decode
  import wbb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 256,
  localparam int unsigned IDX_W   = ADDR_W
) (
  input  logic [ADDR_W-1:2]  adr_i,
  input  logic [LANES-1:0]   sel_i,
  input  logic [BUS_W-1:0]   dat_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [1:0]         off_o,
  output logic [LANE_W-1:0]  wbyte_o
);
  assign off_o   = sel_to_off(sel_i);
  assign idx_o   = {adr_i, off_o};
  assign wbyte_o = lane_get(dat_i, off_o);
  assign hit_o   = $onehot(sel_i) && (int'(idx_o) < int'(NUM_REGS));
endmodule

// File: rtl/wbb_reg_bank.sv
module wbb_reg_bank
  import wbb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  parameter int unsigned IDX_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wen_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [LANE_W-1:0]          wbyte_i,
  output logic [LANE_W-1:0]          rbyte_o,
  output logic [NUM_REGS*LANE_W-1:0] regs_o
);
  logic [LANE_W-1:0] q   [NUM_REGS];
  logic [LANE_W-1:0] sel [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       q[i] <= '0;
      else if (wen_i && int'(idx_i) == i)                q[i] <= wbyte_i;
    end
    assign sel[i] = (int'(idx_i) == i) ? q[i] : '0;
    assign regs_o[i*LANE_W +: LANE_W] = q[i];

    // R3: a register moves only on a write to its own index
    a_r3_only_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wen_i && int'(idx_i) == i) |=> $stable(q[i]));
  end

  always_comb begin
    rbyte_o = '0;
    for (int i = 0; i < NUM_REGS; i++) rbyte_o = rbyte_o | sel[i];
  end
endmodule

// File: rtl/wbb_handshake.sv
module wbb_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_i,
  input  logic stb_i,
  output logic strobe_o,
  output logic ack_o
);
  logic req, ack_q;
  assign req      = cyc_i & stb_i;
  assign strobe_o = req & ~ack_q;
  assign ack_o    = ack_q & req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= strobe_o;
  end

  a_r1_single_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r1_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i && !ack_o) |=> (ack_o || !(cyc_i && stb_i)));
  a_r2_ack_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |-> !ack_o);
endmodule

// File: rtl/wbb_byte_regs.sv
module wbb_byte_regs
  import wbb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 256,
  localparam int unsigned IDX_W   = ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cyc_i,
  input  logic                       stb_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:2]          adr_i,
  input  logic [3:0]                 sel_i,
  input  logic [31:0]                dat_i,
  output logic [31:0]                dat_o,
  output logic                       ack_o,
  output logic [NUM_REGS*8-1:0]      regs_o
);
  logic             hit, strobe, wen;
  logic [IDX_W-1:0] idx;
  logic [1:0]       off;
  logic [7:0]       wbyte, rbyte;
  logic [31:0]      rdata_q;
  logic [3:0]       lane_nz;

  wbb_lane_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .adr_i(adr_i), .sel_i(sel_i), .dat_i(dat_i),
    .hit_o(hit), .idx_o(idx), .off_o(off), .wbyte_o(wbyte)
  );

  wbb_handshake u_hs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i),
    .strobe_o(strobe), .ack_o(ack_o)
  );

  assign wen = strobe & we_i & hit;

  wbb_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wen_i(wen), .idx_i(idx),
    .wbyte_i(wbyte), .rbyte_o(rbyte), .regs_o(regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (strobe) rdata_q <= (!we_i && hit) ? lane_put(rbyte, off) : '0;
  end

  assign dat_o = ack_o ? rdata_q : '0;

  for (genvar l = 0; l < 4; l++) begin : g_nz
    assign lane_nz[l] = |dat_o[l*8 +: 8];
  end

  a_r5_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_nz) <= 1);
  a_r6_miss_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !hit) |=> (dat_o == '0));
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (dat_o == '0));
endmodule

// File: tb/wbb_byte_regs_bench.sv
module wbb_byte_regs_bench;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NREG   = 64;

  logic clk = 0, rst_ni = 0;
  logic cyc = 0, stb = 0, we = 0;
  logic [ADDR_W-1:2] adr = '0;
  logic [3:0] sel = '0;
  logic [31:0] din = '0, dout;
  logic ack;
  logic [NREG*8-1:0] regs;

  logic [7:0] model [NREG];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wbb_byte_regs #(.ADDR_W(ADDR_W), .NUM_REGS(NREG)) u_wbb_byte_regs (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .sel_i(sel), .dat_i(din), .dat_o(dout), .ack_o(ack), .regs_o(regs)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    logic [NREG*8-1:0] e;
    for (int k = 0; k < NREG; k++) e[k*8 +: 8] = model[k];
    n_run++;
    if (regs !== e) begin
      n_fail++;
      $display("FAIL %s regs actual=%h expected=%h", req, regs, e);
    end
  endtask

  // one bus transfer; returns ack in its cycle and read data
  task automatic xfer(input logic w, input int word, input logic [3:0] s,
                      input logic [31:0] d, output logic got_ack, output logic [31:0] rd,
                      output logic ack_after);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = word[ADDR_W-3:0]; sel = s; din = d;
    @(negedge clk);
    got_ack = ack; rd = dout;
    @(posedge clk); #1;
    cyc = 0; stb = 0; we = 0; din = '0; sel = '0;
    @(negedge clk);
    ack_after = ack;
  endtask

  function automatic int off_of(input logic [3:0] s);
    case (s) 4'b1000: return 0; 4'b0100: return 1; 4'b0010: return 2; default: return 3; endcase
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R7 ack in reset", {63'd0, ack}, 64'd0);
    chk("R8 dat_o in reset", {32'd0, dout}, 64'd0);
    chk_regs("R7 regs zero");
    rst_ni = 1;
    @(negedge clk);
    chk_regs("R9 regs after reset release");
  endtask

  task automatic t_write_read();
    logic a, a2; logic [31:0] rd;
    logic [3:0] sels [4] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001};
    for (int w = 0; w < 16; w += 5) begin
      for (int j = 0; j < 4; j++) begin
        logic [7:0] v = 8'(8'h11 * (j + 1) + w);
        logic [31:0] d = {4{~v}};
        int o = off_of(sels[j]);
        d[31-8*o -: 8] = v;  // only the named lane carries the value
        xfer(1, w, sels[j], d, a, rd, a2);
        model[w*4 + o] = v;
        chk("R1 write ack", {63'd0, a}, 64'd1);
        chk("R1 ack drops", {63'd0, a2}, 64'd0);
        chk("R8 write ack data", {32'd0, rd}, 64'd0);
      end
      chk_regs("R3 R4 R9 word write");
      for (int j = 0; j < 4; j++) begin
        int o = off_of(sels[j]);
        logic [31:0] e = 32'({model[w*4+o], 24'd0} >> (8*o));
        xfer(0, w, sels[j], 32'hdead_beef, a, rd, a2);
        chk("R1 read ack", {63'd0, a}, 64'd1);
        chk("R5 read lane", {32'd0, rd}, {32'd0, e});
      end
    end
  endtask

  task automatic t_broadcast();
    logic a, a2; logic [31:0] rd;
    xfer(1, 7, 4'b0010, {4{8'h5a}}, a, rd, a2);
    model[30] = 8'h5a;
    chk_regs("R3 broadcast byte");
    xfer(1, 7, 4'b0001, 32'h0102_03c3, a, rd, a2);
    model[31] = 8'hc3;
    chk_regs("R4 off-lane data ignored");
  endtask

  task automatic t_bad_sel();
    logic a, a2; logic [31:0] rd;
    logic [3:0] bad [3] = '{4'b1100, 4'b0000, 4'b1111};
    for (int j = 0; j < 3; j++) begin
      xfer(1, 0, bad[j], 32'hffff_ffff, a, rd, a2);
      chk("R6 bad sel write ack", {63'd0, a}, 64'd1);
      chk_regs("R6 bad sel no write");
      xfer(0, 0, bad[j], '0, a, rd, a2);
      chk("R6 bad sel read ack", {63'd0, a}, 64'd1);
      chk("R6 bad sel read zero", {32'd0, rd}, 64'd0);
    end
  endtask

  task automatic t_out_of_range();
    logic a, a2; logic [31:0] rd;
    xfer(1, NREG/4 + 3, 4'b1000, 32'h7777_7777, a, rd, a2);
    chk("R10 range write ack", {63'd0, a}, 64'd1);
    chk_regs("R10 range no write");
    xfer(0, NREG/4 + 3, 4'b1000, '0, a, rd, a2);
    chk("R10 range read zero", {32'd0, rd}, 64'd0);
  endtask

  task automatic t_no_cyc();
    logic seen = 0;
    @(negedge clk);
    cyc = 0; stb = 1; we = 1; adr = 6'd1; sel = 4'b1000; din = 32'h99999999;
    repeat (3) begin @(negedge clk); seen |= ack; end
    stb = 0; we = 0;
    chk("R2 no ack without cyc", {63'd0, seen}, 64'd0);
    chk_regs("R2 no write without cyc");
    chk("R8 idle data", {32'd0, dout}, 64'd0);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    t_broadcast();
    t_bad_sel();
    t_out_of_range();
    t_no_cyc();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule